// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic-logic unit for the integer datapath. It is built from `WIDTH` identical one-bit slices, except that the most significant slice is a special variant. Each slice always forms the AND, the OR and the full-adder sum of its operand bits. A shared two-bit operation code then picks which of these results appears at that bit of the output. Carries ripple upward from bit 0 to the top bit.

A single negate line turns the adder into a subtractor. It complements every bit of the second operand and also supplies the carry into bit 0. The signed less-than operation uses the same subtraction. The top slice reports the corrected sign of the difference (sign XOR overflow), and that value is routed back into bit 0. Every other bit of the result is forced to zero in this mode.

The block also drives three flags:
- a zero flag, taken from the result;
- a signed overflow flag;
- the carry out of the top bit.

The block holds no state and has no clock. A decode stage drives `op_sel` and `b_negate`, and the result is consumed within the same cycle.

Top module: `slice_alu`

## Requirements
- R1: With `op_sel` = 0 the result is the bitwise AND of `opnd_a` with the effective second operand. The effective second operand is `opnd_b` when `b_negate` = 0 and `~opnd_b` when `b_negate` = 1.
- R2: With `op_sel` = 1 the result is the bitwise OR of `opnd_a` with the effective second operand, defined as in R1.
- R3: With `op_sel` = 2 and `b_negate` = 0, `{carry_out, result}` equals the unsigned sum `opnd_a + opnd_b` taken as WIDTH+1 bits.
- R4: With `op_sel` = 2 and `b_negate` = 1, `result` equals `opnd_a - opnd_b` modulo 2^WIDTH. In this mode `carry_out` is 1 exactly when `opnd_a >= opnd_b` as unsigned values.
- R5: With `op_sel` = 3 and `b_negate` = 1, `result` is 1 when `opnd_a < opnd_b` as two's-complement signed values and 0 otherwise. Bits WIDTH-1 to 1 are always 0. The answer is correct even when the internal subtraction overflows, for example for 0x80000000 against 0x7FFFFFFF.
- R6: With `op_sel` = 2 and `b_negate` = 0, `ovf` is 1 exactly when the signed sum of the operands falls outside the signed WIDTH-bit range.
- R7: With `op_sel` = 2 and `b_negate` = 1, `ovf` is 1 exactly when the signed difference falls outside the signed WIDTH-bit range.
- R8: `zero` is 1 exactly when every bit of `result` is 0, for every operation. After a subtraction this means `zero` = 1 exactly when the two operands are equal.
- R9: For every operation, `ovf` and `carry_out` report the adder's signed overflow and top carry, computed on `opnd_a`, the effective second operand and a carry-in equal to `b_negate`. With `op_sel` = 3 and `b_negate` = 0, bit 0 of `result` is the top bit of that sum XOR that overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, before optional complement |
| b_negate | input | 1 | Complements the second operand and supplies carry-in of bit 0 |
| op_sel | input | 2 | 0 AND, 1 OR, 2 adder sum, 3 signed less-than |
| result | output | WIDTH | Selected result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of the adder |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
Two of the block's functions meet in the signed less-than operation: the overflow detector and the less-than decision both act on the same subtraction. The overflow detector has to flip the less-than answer that the raw sign would give. This is provoked with the operand pairs 0x80000000/0x7FFFFFFF and 0x7FFFFFFF/0x80000000, whose difference overflows. The result is judged against a signed comparison computed arithmetically in the bench. A second meeting point is subtraction of equal operands. There the zero flag and the carry out must both be 1 in the same evaluation. This case is judged together with an exhaustive sweep of a 4-bit instance over all operand pairs and operation codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_SUM  = 2'd2,
        OP_LESS = 2'd3
    } alu_op_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    b_negate,
    input  logic    carry_in,
    input  logic    less_in,
    input  alu_op_e op,
    output logic    res_bit,
    output logic    carry_next
);
    logic b_eff;
    logic and_r;
    logic or_r;
    logic sum_r;

    // All three candidate results are formed every time; op only selects.
    always_comb begin
        b_eff      = b_bit ^ b_negate;
        and_r      = a_bit & b_eff;
        or_r       = a_bit | b_eff;
        sum_r      = a_bit ^ b_eff ^ carry_in;
        carry_next = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
    end

    always_comb begin
        unique case (op)
            OP_AND:  res_bit = and_r;
            OP_OR:   res_bit = or_r;
            OP_SUM:  res_bit = sum_r;
            OP_LESS: res_bit = less_in;
            default: res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_top_slice.sv
module alu_top_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    b_negate,
    input  logic    carry_in,
    input  logic    less_in,
    input  alu_op_e op,
    output logic    res_bit,
    output logic    carry_next,
    output logic    set_out,
    output logic    ovf_out
);
    logic b_eff;
    logic sum_r;

    always_comb begin
        b_eff      = b_bit ^ b_negate;
        sum_r      = a_bit ^ b_eff ^ carry_in;
        carry_next = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
        set_out    = sum_r;
        // Adder inputs agree in sign but the sum sign differs.
        ovf_out    = (a_bit == b_eff) && (sum_r != a_bit);
    end

    always_comb begin
        unique case (op)
            OP_AND:  res_bit = a_bit & b_eff;
            OP_OR:   res_bit = a_bit | b_eff;
            OP_SUM:  res_bit = sum_r;
            OP_LESS: res_bit = less_in;
            default: res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_clear
);
    always_comb all_clear = ~(|vec);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             b_negate,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf,
    output logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op_e;
    logic [WIDTH:0]   carry;
    logic             top_set;
    logic             top_ovf;
    logic             less_bit0;

    assign op_e      = alu_op_e'(op_sel);
    assign carry[0]  = b_negate;
    // Overflow-corrected sign of the top sum drives the less-than bit.
    assign less_bit0 = top_set ^ top_ovf;

    for (genvar i = 0; i < MSB; i++) begin : g_slice
        logic less_w;
        if (i == 0) begin : g_lsb
            assign less_w = less_bit0;
        end else begin : g_mid
            assign less_w = 1'b0;
        end
        alu_bit_slice u_bit (
            .a_bit      (opnd_a[i]),
            .b_bit      (opnd_b[i]),
            .b_negate   (b_negate),
            .carry_in   (carry[i]),
            .less_in    (less_w),
            .op         (op_e),
            .res_bit    (result[i]),
            .carry_next (carry[i+1])
        );
    end

    alu_top_slice u_top (
        .a_bit      (opnd_a[MSB]),
        .b_bit      (opnd_b[MSB]),
        .b_negate   (b_negate),
        .carry_in   (carry[MSB]),
        .less_in    (1'b0),
        .op         (op_e),
        .res_bit    (result[MSB]),
        .carry_next (carry[WIDTH]),
        .set_out    (top_set),
        .ovf_out    (top_ovf)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .vec       (result),
        .all_clear (zero)
    );

    assign ovf       = top_ovf;
    assign carry_out = carry[WIDTH];
endmodule

// File: rtl/slice_alu_props.sv
module slice_alu_props #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         bneg,
    input logic [1:0]   op,
    input logic [W-1:0] res,
    input logic         zero,
    input logic         ovf,
    input logic         cout
);
    logic [W-1:0]        b_eff;
    logic [W:0]          u_sum;
    logic signed [W:0]   s_sum;
    logic signed [W:0]   s_diff;

    always_comb begin
        b_eff  = bneg ? ~b : b;
        u_sum  = {1'b0, a} + {1'b0, b};
        s_sum  = {a[W-1], a} + {b[W-1], b};
        s_diff = {a[W-1], a} - {b[W-1], b};
    end

    always_comb begin
        if (op == 2'd0) begin
            a_r1_and: assert (res == (a & b_eff));
        end
        if (op == 2'd1) begin
            a_r2_or: assert (res == (a | b_eff));
        end
        if (op == 2'd2 && !bneg) begin
            a_r3_add: assert ({cout, res} == u_sum);
            a_r6_add_ovf: assert (ovf == (s_sum[W] != s_sum[W-1]));
        end
        if (op == 2'd2 && bneg) begin
            a_r4_sub: assert (res == W'(a - b) && cout == (a >= b));
            a_r7_sub_ovf: assert (ovf == (s_diff[W] != s_diff[W-1]));
            a_r8_zero_eq: assert (zero == (a == b));
        end
        if (op == 2'd3 && bneg) begin
            a_r5_slt: assert (res == W'($signed(a) < $signed(b)));
        end
    end
endmodule

bind slice_alu slice_alu_props #(.W(WIDTH)) u_props (
    .a    (opnd_a),
    .b    (opnd_b),
    .bneg (b_negate),
    .op   (op_sel),
    .res  (result),
    .zero (zero),
    .ovf  (ovf),
    .cout (carry_out)
);

// File: tb/slice_alu_test.sv
module slice_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int WBIG       = 32;
    localparam int WSMALL     = 4;

    typedef struct packed {
        logic [31:0] res;
        logic        z;
        logic        v;
        logic        c;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [WBIG-1:0]   a_big, b_big, r_big;
    logic              n_big, z_big, v_big, c_big;
    logic [1:0]        o_big;
    logic [WSMALL-1:0] a_sm, b_sm, r_sm;
    logic              n_sm, z_sm, v_sm, c_sm;
    logic [1:0]        o_sm;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    slice_alu #(.WIDTH(WBIG)) uut (
        .opnd_a(a_big), .opnd_b(b_big), .b_negate(n_big), .op_sel(o_big),
        .result(r_big), .zero(z_big), .ovf(v_big), .carry_out(c_big)
    );

    slice_alu #(.WIDTH(WSMALL)) uut_small (
        .opnd_a(a_sm), .opnd_b(b_sm), .b_negate(n_sm), .op_sel(o_sm),
        .result(r_sm), .zero(z_sm), .ovf(v_sm), .carry_out(c_sm)
    );

    function automatic exp_t model(logic [31:0] a, logic [31:0] b,
                                   logic bneg, logic [1:0] op, int w);
        logic [63:0] mask, a64, bb, sum, s, r;
        logic        sa, sb, ss;
        exp_t e;
        mask = (64'd1 << w) - 64'd1;
        a64  = {32'd0, a} & mask;
        bb   = bneg ? (~{32'd0, b}) & mask : {32'd0, b} & mask;
        sum  = a64 + bb + {63'd0, bneg};
        s    = sum & mask;
        sa   = a64[w-1];
        sb   = bb[w-1];
        ss   = s[w-1];
        e.c  = sum[w];
        e.v  = (sa == sb) && (ss != sa);
        case (op)
            2'd0:    r = a64 & bb;
            2'd1:    r = a64 | bb;
            2'd2:    r = s;
            default: r = {63'd0, ss ^ e.v};
        endcase
        e.res = r[31:0];
        e.z   = (r == 64'd0);
        return e;
    endfunction

    function automatic string tag_res(logic bneg, logic [1:0] op);
        case (op)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return bneg ? "R4" : "R3";
            default: return bneg ? "R5" : "R9";
        endcase
    endfunction

    function automatic string tag_flag(logic bneg, logic [1:0] op);
        if (op == 2'd2) return bneg ? "R7" : "R6";
        return "R9";
    endfunction

    task automatic judge(string tag, logic [31:0] act, logic [31:0] exp,
                         logic [31:0] a, logic [31:0] b);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, exp);
        end
    endtask

    task automatic run_big(logic [31:0] a, logic [31:0] b, logic bneg, logic [1:0] op);
        exp_t e;
        @(negedge clk);
        a_big = a; b_big = b; n_big = bneg; o_big = op;
        @(posedge clk); #1;
        e = model(a, b, bneg, op, WBIG);
        judge(tag_res(bneg, op), r_big, e.res, a, b);
        judge("R8 zero", {31'd0, z_big}, {31'd0, e.z}, a, b);
        judge(tag_flag(bneg, op), {31'd0, v_big}, {31'd0, e.v}, a, b);
        judge(op == 2'd2 ? tag_res(bneg, op) : "R9", {31'd0, c_big}, {31'd0, e.c}, a, b);
    endtask

    task automatic run_small(logic [3:0] a, logic [3:0] b, logic bneg, logic [1:0] op);
        exp_t e;
        @(negedge clk);
        a_sm = a; b_sm = b; n_sm = bneg; o_sm = op;
        @(posedge clk); #1;
        e = model({28'd0, a}, {28'd0, b}, bneg, op, WSMALL);
        judge(tag_res(bneg, op), {28'd0, r_sm}, e.res, {28'd0, a}, {28'd0, b});
        judge("R8 zero", {31'd0, z_sm}, {31'd0, e.z}, {28'd0, a}, {28'd0, b});
        judge(tag_flag(bneg, op), {31'd0, v_sm}, {31'd0, e.v}, {28'd0, a}, {28'd0, b});
        judge("R9 carry", {31'd0, c_sm}, {31'd0, e.c}, {28'd0, a}, {28'd0, b});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr_a;
        logic [31:0] lfsr_b;
        a_big = '0; b_big = '0; n_big = 1'b0; o_big = 2'd0;
        a_sm = '0; b_sm = '0; n_sm = 1'b0; o_sm = 2'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state with all inputs zero: AND of zeros, zero flag set (R8).
        judge("R8 idle result", r_big, 32'd0, 32'd0, 32'd0);
        judge("R8 idle zero", {31'd0, z_big}, 32'd1, 32'd0, 32'd0);

        // R5 boundary pairs whose difference overflows.
        run_big(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'd3);
        judge("R5 min<max", r_big, 32'd1, a_big, b_big);
        run_big(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2'd3);
        judge("R5 max<min", r_big, 32'd0, a_big, b_big);
        // R7 the same pairs under subtract overflow.
        run_big(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'd2);
        judge("R7 ovf", {31'd0, v_big}, 32'd1, a_big, b_big);
        run_big(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2'd2);
        run_big(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'd2);
        judge("R6 ovf", {31'd0, v_big}, 32'd1, a_big, b_big);
        run_big(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'd2);
        judge("R3 wrap carry", {31'd0, c_big}, 32'd1, a_big, b_big);
        // R8 and R4: equal operands give zero with carry out.
        run_big(32'h1234_5678, 32'h1234_5678, 1'b1, 2'd2);
        judge("R8 sub equal", {31'd0, z_big}, 32'd1, a_big, b_big);
        judge("R4 carry equal", {31'd0, c_big}, 32'd1, a_big, b_big);
        run_big(32'hF0F0_00FF, 32'h0FF0_F00F, 1'b0, 2'd0);
        run_big(32'hF0F0_00FF, 32'h0FF0_F00F, 1'b1, 2'd1);

        lfsr_a = 32'hACE1_2468;
        lfsr_b = 32'h1357_9BDF;
        for (int k = 0; k < 150; k++) begin
            for (int m = 0; m < 8; m++) begin
                run_big(lfsr_a, lfsr_b, m[2], m[1:0]);
            end
            lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
            lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
        end

        // Exhaustive sweep of the 4-bit instance, all modes (R1-R9 covered).
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                for (int m = 0; m < 8; m++) begin
                    run_small(ia[3:0], ib[3:0], m[2], m[1:0]);
                end
            end
        end
        finish_run();
    end
endmodule